// File: doc/BRIEF.md
# Handshake Rule Monitor

A passive observer for one point-to-point channel that moves data with a VALID/READY handshake. It samples the clock, reset, VALID, READY and a payload bus of configurable width. It never drives any of them. On every rising edge where VALID and READY are both high it counts one completed transfer. The count is reported through a one-cycle strobe and a saturating counter.

The monitor also polices the source side of the handshake. The destination may raise READY before, together with, or after VALID. A source that has raised VALID must hold it, and hold its payload still, until the transfer is taken. A source must not sit idle while READY is offered for longer than a configurable number of cycles. VALID must be low in the first cycle after reset is released. Each broken rule sets its own sticky flag, and a single-cycle error pulse marks every cycle in which at least one rule broke. All outputs are registered, so every result appears one clock after the edge that sampled its cause.

Top module: `hs_monitor`

## Requirements
- R1: `xfer_strobe` is high for exactly the cycle after each rising edge that samples `valid` and `ready` both high. It is low after every other edge.
- R2: `xfer_count` rises by one with each strobe and stops at its all-ones value (2^CNT_W-1). It never decreases except through reset.
- R3: READY before VALID, READY together with VALID, and READY after VALID all complete without any error. A VALID held for many cycles against a low READY, with a steady payload, is not an error.
- R4: If the previous edge sampled `valid` high with `ready` low, and the current edge samples `valid` low, the dropped-VALID flag (`err_sticky` bit 0) is set.
- R5: If the previous edge sampled `valid` high with `ready` low, and the current edge samples `valid` high with a different `payload`, the unstable-payload flag (`err_sticky` bit 1) is set.
- R6: On the STALL_LIMIT-th consecutive edge that samples `ready` high and `valid` low, the starved-READY flag (`err_sticky` bit 2) is set. This fires only once per unbroken run. A run shorter than STALL_LIMIT raises nothing.
- R7: If `valid` is high on the first edge after `rst` falls, the early-VALID flag (`err_sticky` bit 3) is set.
- R8: `err_pulse` is high for one cycle after each edge that detects any error. Flags in `err_sticky` stay set until reset.
- R9: Reset is synchronous and active-high. It clears the strobe, the count, the pulse and all flags, and no rule is checked on an edge that samples reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the observed channel |
| rst | input | 1 | Synchronous active-high reset |
| valid | input | 1 | Observed source VALID |
| ready | input | 1 | Observed destination READY |
| payload | input | PAYLOAD_W | Observed payload bus |
| xfer_strobe | output | 1 | One cycle high per completed transfer |
| xfer_count | output | CNT_W | Saturating count of completed transfers |
| err_pulse | output | 1 | High for one cycle after any rule break |
| err_sticky | output | 4 | Sticky flags: bit0 dropped VALID, bit1 unstable payload, bit2 starved READY, bit3 early VALID |

## Verification
The monitor holds three pieces of state: a pending-offer bit with a payload snapshot, a stall run counter, and a first-cycle marker. If any of these is wrong, a wrong flag shows up at `err_sticky` and `err_pulse` exactly one cycle after the offending edge. A stall counter that is off by one moves the starved-READY pulse one cycle early or late, or makes it repeat within one run. Because the flags are sticky, a spurious detection stays visible at the ports from then on. A counter fault shows on `xfer_count` in the cycle after the strobe, most visibly at saturation.

// File: rtl/hs_mon_pkg.sv
package hs_mon_pkg;

    // Rule-break flags; the dropped bit is the LSB of the packed form.
    typedef struct packed {
        logic early_valid;
        logic starve;
        logic unstable;
        logic dropped;
    } hs_err_t;

    localparam int ERR_W = $bits(hs_err_t);

    function automatic hs_err_t err_merge(input hs_err_t a, input hs_err_t b);
        return hs_err_t'(a | b);
    endfunction

    function automatic logic err_any(input hs_err_t e);
        return |e;
    endfunction

endpackage

// File: rtl/hs_xfer_counter.sv
module hs_xfer_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    output logic             strobe,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             strobe_q;
    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
            count_q  <= '0;
        end else begin
            strobe_q <= fire;
            if (fire && (count_q != CNT_MAX))
                count_q <= count_q + 1'b1;
        end
    end

    assign strobe = strobe_q;
    assign count  = count_q;
endmodule

// File: rtl/hs_stall_timer.sv
module hs_stall_timer #(
    parameter int STALL_LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic ready_idle,
    output logic expired
);
    localparam int            TW      = $clog2(STALL_LIMIT + 1);
    localparam logic [TW-1:0] T_SAT   = TW'(STALL_LIMIT);
    localparam logic [TW-1:0] T_FINAL = TW'(STALL_LIMIT - 1);

    logic [TW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)
            run_q <= '0;
        else if (!ready_idle)
            run_q <= '0;
        else if (run_q != T_SAT)
            run_q <= run_q + 1'b1;
    end

    // Fires on the edge that completes the STALL_LIMIT-th idle cycle only.
    assign expired = ready_idle && (run_q == T_FINAL);
endmodule

// File: rtl/hs_rule_check.sv
module hs_rule_check
    import hs_mon_pkg::*;
#(
    parameter int PAYLOAD_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 valid,
    input  logic                 ready,
    input  logic [PAYLOAD_W-1:0] payload,
    input  logic                 starve_hit,
    output logic                 pulse,
    output hs_err_t              sticky
);
    logic                 pend_q;
    logic [PAYLOAD_W-1:0] snap_q;
    logic                 first_q;
    logic                 pulse_q;
    hs_err_t              sticky_q;
    hs_err_t              now_err;

    always_comb begin
        now_err = '0;
        if (!rst) begin
            now_err.dropped     = pend_q && !valid;
            now_err.unstable    = pend_q && valid && (payload != snap_q);
            now_err.starve      = starve_hit;
            now_err.early_valid = first_q && valid;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= 1'b0;
            snap_q   <= '0;
            first_q  <= 1'b1;
            pulse_q  <= 1'b0;
            sticky_q <= '0;
        end else begin
            pend_q   <= valid && !ready;
            snap_q   <= payload;
            first_q  <= 1'b0;
            pulse_q  <= err_any(now_err);
            sticky_q <= err_merge(sticky_q, now_err);
        end
    end

    assign pulse  = pulse_q;
    assign sticky = sticky_q;
endmodule

// File: rtl/hs_monitor.sv
module hs_monitor
    import hs_mon_pkg::*;
#(
    parameter int PAYLOAD_W   = 32,
    parameter int CNT_W       = 16,
    parameter int STALL_LIMIT = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 valid,
    input  logic                 ready,
    input  logic [PAYLOAD_W-1:0] payload,
    output logic                 xfer_strobe,
    output logic [CNT_W-1:0]     xfer_count,
    output logic                 err_pulse,
    output logic [3:0]           err_sticky
);
    logic    fire;
    logic    ready_idle;
    logic    starve_hit;
    hs_err_t flags;

    assign fire       = valid && ready;
    assign ready_idle = ready && !valid;

    hs_xfer_counter #(.CNT_W(CNT_W)) u_count (
        .clk    (clk),
        .rst    (rst),
        .fire   (fire),
        .strobe (xfer_strobe),
        .count  (xfer_count)
    );

    hs_stall_timer #(.STALL_LIMIT(STALL_LIMIT)) u_stall (
        .clk        (clk),
        .rst        (rst),
        .ready_idle (ready_idle),
        .expired    (starve_hit)
    );

    hs_rule_check #(.PAYLOAD_W(PAYLOAD_W)) u_rules (
        .clk        (clk),
        .rst        (rst),
        .valid      (valid),
        .ready      (ready),
        .payload    (payload),
        .starve_hit (starve_hit),
        .pulse      (err_pulse),
        .sticky     (flags)
    );

    assign err_sticky = flags;
endmodule

// File: rtl/hs_monitor_chk.sv
module hs_monitor_chk #(
    parameter int PAYLOAD_W = 32,
    parameter int CNT_W     = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 valid,
    input logic                 ready,
    input logic [PAYLOAD_W-1:0] payload,
    input logic                 xfer_strobe,
    input logic [CNT_W-1:0]     xfer_count,
    input logic                 err_pulse,
    input logic [3:0]           err_sticky
);
    // R1
    strobe_cause_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_strobe |-> $past(valid && ready));

    // R2
    count_monotone_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (xfer_count >= $past(xfer_count)));

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (xfer_count != $past(xfer_count))) |-> xfer_strobe);

    // R4
    drop_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(valid && !ready) && !valid) |=> err_sticky[0]);

    // R5
    unstable_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(valid && !ready) && valid && (payload != $past(payload)))
        |=> err_sticky[1]);

    // R7
    early_flag_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && valid) |=> err_sticky[3]);

    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (($past(err_sticky) & ~err_sticky) == 4'b0000));

    // R8
    pulse_flag_chk: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> (err_sticky != 4'b0000));
endmodule

bind hs_monitor hs_monitor_chk #(.PAYLOAD_W(PAYLOAD_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .valid       (valid),
    .ready       (ready),
    .payload     (payload),
    .xfer_strobe (xfer_strobe),
    .xfer_count  (xfer_count),
    .err_pulse   (err_pulse),
    .err_sticky  (err_sticky)
);

// File: tb/tb_hs_monitor.sv
module tb_hs_monitor;
    localparam int PW = 8;
    localparam int CW = 3;
    localparam int SL = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          valid = 1'b0;
    logic          ready = 1'b0;
    logic [PW-1:0] payload = '0;
    logic          xfer_strobe;
    logic [CW-1:0] xfer_count;
    logic          err_pulse;
    logic [3:0]    err_sticky;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    hs_monitor #(.PAYLOAD_W(PW), .CNT_W(CW), .STALL_LIMIT(SL)) dut (
        .clk(clk), .rst(rst), .valid(valid), .ready(ready), .payload(payload),
        .xfer_strobe(xfer_strobe), .xfer_count(xfer_count),
        .err_pulse(err_pulse), .err_sticky(err_sticky)
    );

    typedef struct packed {
        logic          r;
        logic          v;
        logic          rd;
        logic [PW-1:0] p;
        logic          s;
        logic          e;
        logic [3:0]    st;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 4'b0000}, // R9 reset
        '{1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 4'b0000},
        '{1'b0, 1'b1, 1'b0, 8'hA1, 1'b0, 1'b0, 4'b0000}, // R3 offer
        '{1'b0, 1'b1, 1'b1, 8'hA1, 1'b1, 1'b0, 4'b0000}, // R1 ready after valid
        '{1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 4'b0000},
        '{1'b0, 1'b1, 1'b1, 8'hB2, 1'b1, 1'b0, 4'b0000}, // R3 ready before valid
        '{1'b0, 1'b1, 1'b1, 8'hC3, 1'b1, 1'b0, 4'b0000}, // R3 together
        '{1'b0, 1'b1, 1'b0, 8'hD4, 1'b0, 1'b0, 4'b0000},
        '{1'b0, 1'b1, 1'b0, 8'hE5, 1'b0, 1'b1, 4'b0010}, // R5 payload moved
        '{1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 4'b0011}, // R4 valid dropped
        '{1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 4'b0011},
        '{1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 4'b0011},
        '{1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 4'b0011},
        '{1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 4'b0111}, // R6 fourth idle cycle
        '{1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 4'b0111}, // R6 no repeat
        '{1'b0, 1'b1, 1'b1, 8'h5A, 1'b1, 1'b0, 4'b0111}, // R8 flags held
        '{1'b1, 1'b1, 1'b0, 8'h11, 1'b0, 1'b0, 4'b0000}, // R9 clears
        '{1'b0, 1'b1, 1'b0, 8'h11, 1'b0, 1'b1, 4'b1000}, // R7 early valid
        '{1'b0, 1'b1, 1'b0, 8'h11, 1'b0, 1'b0, 4'b1000},
        '{1'b0, 1'b1, 1'b1, 8'h11, 1'b1, 1'b0, 4'b1000}
    };

    task automatic step(input logic r, input logic v, input logic rd, input logic [PW-1:0] p);
        @(negedge clk);
        rst = r; valid = v; ready = rd; payload = p;
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    initial begin
        for (int i = 0; i < NV; i++) begin
            step(TBL[i].r, TBL[i].v, TBL[i].rd, TBL[i].p);
            check($sformatf("R1 strobe row %0d", i), int'(xfer_strobe), int'(TBL[i].s));
            check($sformatf("R8 pulse row %0d", i), int'(err_pulse), int'(TBL[i].e));
            check($sformatf("R8 flags row %0d", i), int'(err_sticky), int'(TBL[i].st));
        end
        // R2 one transfer since the last reset
        check("R2 count after table", int'(xfer_count), 1);

        // R2 saturation
        for (int k = 0; k < 6; k++) step(1'b0, 1'b1, 1'b1, PW'(k));
        check("R2 count reaches max", int'(xfer_count), 7);
        for (int k = 0; k < 2; k++) step(1'b0, 1'b1, 1'b1, PW'(k + 40));
        check("R2 count saturated", int'(xfer_count), 7);
        check("R1 strobe at saturation", int'(xfer_strobe), 1);
        step(1'b0, 1'b0, 1'b0, '0);
        check("R1 strobe falls", int'(xfer_strobe), 0);

        // R9 violations during reset are ignored
        step(1'b1, 1'b1, 1'b0, 8'h01);
        step(1'b1, 1'b0, 1'b0, 8'h02);
        step(1'b1, 1'b0, 1'b1, 8'h02);
        check("R9 count cleared", int'(xfer_count), 0);
        check("R9 flags cleared", int'(err_sticky), 0);
        check("R9 pulse cleared", int'(err_pulse), 0);

        // R6 a run one short of the limit raises nothing
        step(1'b0, 1'b0, 1'b0, '0);
        for (int k = 0; k < SL - 1; k++) step(1'b0, 1'b0, 1'b1, '0);
        step(1'b0, 1'b1, 1'b1, 8'h33);
        check("R6 short run no flag", int'(err_sticky), 0);
        check("R3 transfer after idle ready", int'(xfer_strobe), 1);

        // R3 long wait with steady payload
        for (int k = 0; k < 10; k++) step(1'b0, 1'b1, 1'b0, 8'h77);
        check("R3 long wait no flag", int'(err_sticky), 0);
        step(1'b0, 1'b1, 1'b1, 8'h77);
        check("R3 long wait completes", int'(xfer_strobe), 1);
        check("R2 count after wait", int'(xfer_count), 2);
        check("R3 no pulse", int'(err_pulse), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule